// File: doc/BRIEF.md
# Indirect Pointer Post-Modify Unit

This block keeps two 8-bit pointer registers that a processor uses for indirect data-memory addressing. Each indirect access through a pointer is flagged by a one-cycle strobe. After that access the pointer can step down by one, step up by one, or stay where it is. A 2-bit code for each pointer selects which of these happens. Both codes sit in the upper nibble of an 8-bit control/status register, and software can read and write every bit of that register.

The processor can load either pointer directly through its own write port, and it can load the whole status register through a third write port. The block drives out both pointer values and the status register contents on every cycle. Address decoding, the memory array and instruction decoding are handled elsewhere.

Top module: `ptr_postmod_unit`

## Requirements
- R1: While reset is asserted and on the first cycle after it, both pointers read 00h and the status register reads F0h, so both mode codes start at 11 (hold).
- R2: Mode code 00 makes the pointer decrease by one on the clock edge that follows an access strobe.
- R3: Mode code 01 makes the pointer increase by one on the clock edge that follows an access strobe.
- R4: Mode codes 10 and 11 leave the pointer unchanged when an access strobe arrives.
- R5: Stepping wraps modulo 256: FFh plus one gives 00h and 00h minus one gives FFh.
- R6: A direct write to a pointer in the same cycle as that pointer's access strobe loads the written value, and no step is applied.
- R7: Status bits [5:4] hold the mode of pointer 0 and bits [7:6] hold the mode of pointer 1. The two pointers step independently and can both step in the same cycle.
- R8: A status write loads all 8 bits, and the new value appears on the next cycle. Without a write the register keeps its value.
- R9: An access strobe uses the mode code held in the register before the edge. A status write in the same cycle only affects later accesses.
- R10: With no strobe and no write, a pointer keeps its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ptr0_we | input | 1 | Direct write enable for pointer 0 |
| ptr0_wdata | input | 8 | Direct write data for pointer 0 |
| ptr1_we | input | 1 | Direct write enable for pointer 1 |
| ptr1_wdata | input | 8 | Direct write data for pointer 1 |
| stat_we | input | 1 | Status register write enable |
| stat_wdata | input | 8 | Status register write data |
| acc0_stb | input | 1 | Indirect access through pointer 0 this cycle |
| acc1_stb | input | 1 | Indirect access through pointer 1 this cycle |
| ptr0 | output | 8 | Current value of pointer 0 |
| ptr1 | output | 8 | Current value of pointer 1 |
| stat | output | 8 | Current status register contents |

## Verification
Directed runs step each pointer through all four mode codes, so decrement, increment and both hold codes can each be told apart. Pointer 0 is stepped up across FFh and pointer 1 is stepped down across 00h to show the wrap. Collision cycles combine a strobe with a pointer write or with a status write, which shows that the write wins and that a status write does not change the mode used by the strobe in its own cycle. A long seeded random run then mixes strobes, writes and mode changes on both pointers at once, which exposes any coupling between the two pointers or any swap of their mode fields.

// File: rtl/ptrmod_pkg.sv
package ptrmod_pkg;

    // Post-access behaviour selected by a 2-bit mode field
    typedef enum logic [1:0] {
        PM_DEC      = 2'b00,
        PM_INC      = 2'b01,
        PM_HOLD     = 2'b10,
        PM_HOLD_ALT = 2'b11
    } pm_mode_e;

    localparam int PM_FIELD_W = 2;

endpackage

// File: rtl/ptrmod_mode_sel.sv
module ptrmod_mode_sel
    import ptrmod_pkg::*;
(
    input  logic [PM_FIELD_W-1:0] field_i,
    output logic                  do_inc_o,
    output logic                  do_dec_o
);

    pm_mode_e mode;

    always_comb begin
        mode     = pm_mode_e'(field_i);
        do_inc_o = 1'b0;
        do_dec_o = 1'b0;
        unique case (mode)
            PM_DEC:      do_dec_o = 1'b1;
            PM_INC:      do_inc_o = 1'b1;
            PM_HOLD,
            PM_HOLD_ALT: ;
        endcase
    end

endmodule

// File: rtl/ptrmod_step.sv
module ptrmod_step #(
    parameter int PTR_W = 8
) (
    input  logic [PTR_W-1:0] cur_i,
    input  logic             do_inc_i,
    input  logic             do_dec_i,
    input  logic             acc_i,
    input  logic             wr_en_i,
    input  logic [PTR_W-1:0] wr_data_i,
    output logic [PTR_W-1:0] nxt_o
);

    localparam logic [PTR_W-1:0] ONE = PTR_W'(1);

    always_comb begin
        nxt_o = cur_i;
        if (wr_en_i) begin
            nxt_o = wr_data_i;              // processor write has priority
        end else if (acc_i && do_inc_i) begin
            nxt_o = cur_i + ONE;            // wraps at the top
        end else if (acc_i && do_dec_i) begin
            nxt_o = cur_i - ONE;            // wraps at the bottom
        end
    end

endmodule

// File: rtl/ptr_postmod_unit.sv
module ptr_postmod_unit #(
    parameter int PTR_W  = 8,
    parameter int STAT_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ptr0_we,
    input  logic [PTR_W-1:0]  ptr0_wdata,
    input  logic              ptr1_we,
    input  logic [PTR_W-1:0]  ptr1_wdata,
    input  logic              stat_we,
    input  logic [STAT_W-1:0] stat_wdata,
    input  logic              acc0_stb,
    input  logic              acc1_stb,
    output logic [PTR_W-1:0]  ptr0,
    output logic [PTR_W-1:0]  ptr1,
    output logic [STAT_W-1:0] stat
);

    import ptrmod_pkg::*;

    localparam int NPTR     = 2;
    localparam int MODE_LSB = STAT_W - NPTR * PM_FIELD_W;
    localparam logic [STAT_W-1:0] STAT_RST =
        {{(NPTR*PM_FIELD_W){1'b1}}, {MODE_LSB{1'b0}}};

    typedef struct packed {
        logic [STAT_W-1:0]           stat;
        logic [NPTR-1:0][PTR_W-1:0]  ptr;
    } state_t;

    state_t st_d, st_q;

    logic [NPTR-1:0]             we_v;
    logic [NPTR-1:0]             acc_v;
    logic [NPTR-1:0]             inc_v;
    logic [NPTR-1:0]             dec_v;
    logic [NPTR-1:0][PTR_W-1:0]  wd_v;
    logic [NPTR-1:0][PTR_W-1:0]  step_v;

    assign we_v  = {ptr1_we, ptr0_we};
    assign acc_v = {acc1_stb, acc0_stb};
    assign wd_v  = {ptr1_wdata, ptr0_wdata};

    // pointer k takes its mode from field k above MODE_LSB
    for (genvar k = 0; k < NPTR; k++) begin : g_ptr
        ptrmod_mode_sel u_sel (
            .field_i  (st_q.stat[MODE_LSB + PM_FIELD_W*k +: PM_FIELD_W]),
            .do_inc_o (inc_v[k]),
            .do_dec_o (dec_v[k])
        );

        ptrmod_step #(.PTR_W(PTR_W)) u_step (
            .cur_i     (st_q.ptr[k]),
            .do_inc_i  (inc_v[k]),
            .do_dec_i  (dec_v[k]),
            .acc_i     (acc_v[k]),
            .wr_en_i   (we_v[k]),
            .wr_data_i (wd_v[k]),
            .nxt_o     (step_v[k])
        );
    end

    always_comb begin
        st_d     = st_q;
        st_d.ptr = step_v;
        if (stat_we) begin
            st_d.stat = stat_wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.stat <= STAT_RST;
            st_q.ptr  <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ptr0 = st_q.ptr[0];
    assign ptr1 = st_q.ptr[1];
    assign stat = st_q.stat;

endmodule

// File: rtl/ptr_postmod_chk.sv
module ptr_postmod_chk #(
    parameter int PTR_W  = 8,
    parameter int STAT_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ptr0_we,
    input logic [PTR_W-1:0]  ptr0_wdata,
    input logic              ptr1_we,
    input logic [PTR_W-1:0]  ptr1_wdata,
    input logic              stat_we,
    input logic [STAT_W-1:0] stat_wdata,
    input logic              acc0_stb,
    input logic              acc1_stb,
    input logic [PTR_W-1:0]  ptr0,
    input logic [PTR_W-1:0]  ptr1,
    input logic [STAT_W-1:0] stat
);

    logic [1:0] m0, m1;
    assign m0 = stat[STAT_W-3:STAT_W-4];
    assign m1 = stat[STAT_W-1:STAT_W-2];

    a_r2_dec_ptr0: assert property (@(posedge clk) disable iff (!rst_n)
        (acc0_stb && !ptr0_we && m0 == 2'b00) |=> ptr0 == PTR_W'($past(ptr0) - 1'b1));

    a_r2_dec_ptr1: assert property (@(posedge clk) disable iff (!rst_n)
        (acc1_stb && !ptr1_we && m1 == 2'b00) |=> ptr1 == PTR_W'($past(ptr1) - 1'b1));

    a_r3_inc_ptr0: assert property (@(posedge clk) disable iff (!rst_n)
        (acc0_stb && !ptr0_we && m0 == 2'b01) |=> ptr0 == PTR_W'($past(ptr0) + 1'b1));

    a_r3_inc_ptr1: assert property (@(posedge clk) disable iff (!rst_n)
        (acc1_stb && !ptr1_we && m1 == 2'b01) |=> ptr1 == PTR_W'($past(ptr1) + 1'b1));

    a_r4_hold_ptr0: assert property (@(posedge clk) disable iff (!rst_n)
        (!ptr0_we && m0[1]) |=> $stable(ptr0));

    a_r4_hold_ptr1: assert property (@(posedge clk) disable iff (!rst_n)
        (!ptr1_we && m1[1]) |=> $stable(ptr1));

    a_r6_write_wins0: assert property (@(posedge clk) disable iff (!rst_n)
        ptr0_we |=> ptr0 == $past(ptr0_wdata));

    a_r6_write_wins1: assert property (@(posedge clk) disable iff (!rst_n)
        ptr1_we |=> ptr1 == $past(ptr1_wdata));

    a_r8_stat_load: assert property (@(posedge clk) disable iff (!rst_n)
        stat_we |=> stat == $past(stat_wdata));

    a_r8_stat_keep: assert property (@(posedge clk) disable iff (!rst_n)
        !stat_we |=> $stable(stat));

    a_r10_idle0: assert property (@(posedge clk) disable iff (!rst_n)
        (!acc0_stb && !ptr0_we) |=> $stable(ptr0));

    a_r10_idle1: assert property (@(posedge clk) disable iff (!rst_n)
        (!acc1_stb && !ptr1_we) |=> $stable(ptr1));

endmodule

bind ptr_postmod_unit ptr_postmod_chk #(.PTR_W(PTR_W), .STAT_W(STAT_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .ptr0_we    (ptr0_we),
    .ptr0_wdata (ptr0_wdata),
    .ptr1_we    (ptr1_we),
    .ptr1_wdata (ptr1_wdata),
    .stat_we    (stat_we),
    .stat_wdata (stat_wdata),
    .acc0_stb   (acc0_stb),
    .acc1_stb   (acc1_stb),
    .ptr0       (ptr0),
    .ptr1       (ptr1),
    .stat       (stat)
);

// File: tb/ptr_postmod_unit_tb.sv
`timescale 1ns/1ps
module ptr_postmod_unit_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ptr0_we = 1'b0, ptr1_we = 1'b0, stat_we = 1'b0;
    logic [7:0] ptr0_wdata = '0, ptr1_wdata = '0, stat_wdata = '0;
    logic       acc0_stb = 1'b0, acc1_stb = 1'b0;
    logic [7:0] ptr0, ptr1, stat;

    int checks = 0;
    int errors = 0;
    logic [7:0] e_p0, e_p1, e_st;

    always #10 clk = ~clk;   // 50 MHz

    ptr_postmod_unit u_dut (
        .clk(clk), .rst_n(rst_n),
        .ptr0_we(ptr0_we), .ptr0_wdata(ptr0_wdata),
        .ptr1_we(ptr1_we), .ptr1_wdata(ptr1_wdata),
        .stat_we(stat_we), .stat_wdata(stat_wdata),
        .acc0_stb(acc0_stb), .acc1_stb(acc1_stb),
        .ptr0(ptr0), .ptr1(ptr1), .stat(stat)
    );

    // reference: mode 00 down, 01 up, 1x hold; write wins; wrap mod 256
    function automatic logic [7:0] ref_ptr(input logic [7:0] cur, input logic [1:0] mode,
                                           input logic acc, input logic we,
                                           input logic [7:0] wd);
        if (we) return wd;
        if (acc && mode == 2'b00) return cur - 8'd1;
        if (acc && mode == 2'b01) return cur + 8'd1;
        return cur;
    endfunction

    task automatic check(input string tag, input string what,
                         input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %02h expected %02h", tag, what, act, exp);
        end
    endtask

    task automatic check_all(input string tag);
        check(tag, "ptr0", ptr0, e_p0);
        check(tag, "ptr1", ptr1, e_p1);
        check(tag, "stat", stat, e_st);
    endtask

    // called just after a falling edge: drive, clock, then compare at the next falling edge
    task automatic cyc(input logic we0, input logic [7:0] wd0,
                       input logic we1, input logic [7:0] wd1,
                       input logic swe, input logic [7:0] swd,
                       input logic a0, input logic a1, input string tag);
        ptr0_we = we0; ptr0_wdata = wd0;
        ptr1_we = we1; ptr1_wdata = wd1;
        stat_we = swe; stat_wdata = swd;
        acc0_stb = a0; acc1_stb = a1;
        e_p0 = ref_ptr(e_p0, e_st[5:4], a0, we0, wd0);
        e_p1 = ref_ptr(e_p1, e_st[7:6], a1, we1, wd1);
        if (swe) e_st = swd;
        @(posedge clk);
        @(negedge clk);
        check_all(tag);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : main
        int unsigned seed_kick;
        seed_kick = $urandom(32'h5EED_0042);
        e_p0 = 8'h00; e_p1 = 8'h00; e_st = 8'hF0;
        repeat (3) @(negedge clk);
        check_all("R1 in reset");
        rst_n = 1'b1;
        @(negedge clk);
        check_all("R1 after reset");

        cyc(0, 0, 0, 0, 0, 0, 0, 0, "R10 idle");
        cyc(0, 0, 0, 0, 0, 0, 1, 1, "R4 code 11 hold");
        // p1 mode 00, p0 mode 01; strobe in same cycle still uses old hold mode
        cyc(0, 0, 0, 0, 1, 8'h15, 1, 1, "R9 old mode used");
        cyc(0, 0, 0, 0, 0, 0, 0, 1, "R5 R2 dec wrap 00->FF");
        cyc(0, 0, 0, 0, 0, 0, 0, 1, "R2 dec");
        cyc(1, 8'hFE, 0, 0, 0, 0, 0, 0, "R6 direct load");
        cyc(0, 0, 0, 0, 0, 0, 1, 0, "R3 inc");
        cyc(0, 0, 0, 0, 0, 0, 1, 0, "R5 R3 inc wrap FF->00");
        cyc(1, 8'h55, 0, 0, 0, 0, 1, 0, "R6 write beats step");
        cyc(0, 0, 1, 8'hA0, 0, 0, 0, 1, "R6 write beats step p1");
        cyc(0, 0, 0, 0, 0, 0, 1, 1, "R7 both step");
        // swap: p1 mode 01, p0 mode 00
        cyc(0, 0, 0, 0, 1, 8'h43, 0, 0, "R8 stat load");
        cyc(0, 0, 0, 0, 0, 0, 1, 1, "R7 field mapping");
        cyc(0, 0, 0, 0, 1, 8'hA7, 0, 0, "R8 stat load");
        cyc(0, 0, 0, 0, 0, 0, 1, 1, "R4 code 10 hold");
        cyc(0, 0, 0, 0, 1, 8'hDC, 0, 0, "R8 stat load");
        cyc(0, 0, 0, 0, 0, 0, 1, 1, "R4 code 11 and 01 mix");

        for (int i = 0; i < 600; i++) begin
            logic [7:0] sw;
            sw = 8'($urandom);
            cyc(($urandom % 6) == 0, 8'($urandom),
                ($urandom % 6) == 0, 8'($urandom),
                ($urandom % 8) == 0, sw,
                ($urandom % 3) != 0, ($urandom % 3) != 0,
                "R7 random mix");
        end

        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule